// File: doc/BRIEF.md
# Walking-One Loopback Pin Tester

This block checks a set of bidirectional pins that an external fixture wires together in pairs, one pin from bank A and one from bank B. At any moment it enables exactly one output driver and drives that pin high. All other pins are released, and external pulldowns hold them low. After a fixed settle interval it looks at the opposite bank. There, only the partner of the driven pin may read high. The driven pin walks through every bank A pin first. Then bank B takes over and drives back towards bank A.

The sweep repeats without end. After the first full sweep with no fault, a pass flag rises. On the first mismatch the tester freezes and reports the global step index as an error code. Step indices run from zero across both directions, so with 120 pins per bank the last step is 239 (0xEF). Most pairs are straight: A pin i pairs with B pin i. Inside a configurable window of bank indices the pairing is mirrored.

Top module: `loopback_walker`

## Requirements
- R1: While reset is held and right after it, fault and sweep_ok are low, fault_code is 0, and only pin 0 (bank A pin 0) is enabled and driven.
- R2: On every cycle exactly one bit of pin_oe is set, and pin_out equals pin_oe.
- R3: Each step keeps its pin driven for SETTLE clocks (16 by default). The opposite bank is compared only in the last of those clocks, so a glitch earlier in the step has no effect.
- R4: Step s drives bit s of the pin vectors. Bits 0..NPINS-1 are bank A and bits NPINS..2*NPINS-1 are bank B. The steps therefore cover all bank A pins in ascending order and then all bank B pins.
- R5: A step passes only when, in the receiving bank, the partner pin reads 1 and every other pin reads 0. Extra high pins in the driving bank are not examined.
- R6: Pin index i pairs with pin i, except for indices MIR_LO <= i < MIR_LO+MIR_LEN (64 and 22 by default). Those pair with 2*MIR_LO+MIR_LEN-1-i. The same mapping applies in both directions.
- R7: After the last step (2*NPINS-1) passes, the sequence restarts at step 0.
- R8: sweep_ok rises in the clock that completes the first fault-free step 2*NPINS-1. It then stays high while no fault occurs.
- R9: On the first failing comparison, fault sets and fault_code takes the step index of the failing step. sweep_ok clears. The driven pin and the code stay frozen until reset.
- R10: fault_code reads 0 whenever fault is low.
- R11: Asserting reset from any state, including a frozen fault, restarts the sequence at step 0 with both flags cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_oe | output | 2*NPINS | Per-pin output enable, bank A in the low half |
| pin_out | output | 2*NPINS | Per-pin output value |
| pin_in | input | 2*NPINS | Per-pin level read back from the pads |
| sweep_ok | output | 1 | A complete fault-free sweep has finished |
| fault | output | 1 | A mismatch was found; the tester is halted |
| fault_code | output | $clog2(2*NPINS) | Step index of the failing step |

## Verification
The embedded properties check on every cycle that:
- only one driver is active;
- the driven pin holds still through the settle window;
- the step wraps to 0 after the last one;
- a pass indication rises only as the walk wraps;
- pass and fault never coexist;
- a fault freezes the driver and code;
- the code stays zero while no fault is present.

Only the bench scenarios can show that the comparison uses the right partner. That covers the mirrored window and the ignored driving bank. The scenarios also show that the pass flag waits for an entire sweep and that each injected open, short or stuck pin yields its exact step number. This includes the last step, 0xEF, and a fault that arrives after a pass has already been reported.

// File: rtl/loopback_walker.sv
module loopback_walker #(
  parameter int NPINS   = 120,
  parameter int SETTLE  = 16,
  parameter int MIR_LO  = 64,
  parameter int MIR_LEN = 22,
  localparam int TOT    = 2 * NPINS,
  localparam int SW     = $clog2(TOT)
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [TOT-1:0] pin_oe,
  output logic [TOT-1:0] pin_out,
  input  logic [TOT-1:0] pin_in,
  output logic           sweep_ok,
  output logic           fault,
  output logic [SW-1:0]  fault_code
);
  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] LAST_CNT  = CW'(SETTLE - 1);
  localparam logic [SW-1:0] LAST_STEP = SW'(TOT - 1);

  function automatic logic [SW-1:0] mate(input logic [SW-1:0] i);
    if (int'(i) >= MIR_LO && int'(i) < MIR_LO + MIR_LEN)
      return SW'(2 * MIR_LO + MIR_LEN - 1 - int'(i));
    return i;
  endfunction

  logic [SW-1:0]    step;
  logic [CW-1:0]    cnt;
  logic [SW-1:0]    code_q;
  logic             dir_b;
  logic [SW-1:0]    local_idx;
  logic [NPINS-1:0] rx, want;

  assign dir_b     = step >= SW'(NPINS);
  assign local_idx = dir_b ? step - SW'(NPINS) : step;
  assign rx        = dir_b ? pin_in[NPINS-1:0] : pin_in[TOT-1:NPINS];
  assign pin_oe    = {{(TOT-1){1'b0}}, 1'b1} << step;
  assign pin_out   = pin_oe;
  assign fault_code = code_q;

  always_comb begin
    want = '0;
    want[mate(local_idx)] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step     <= '0;
      cnt      <= '0;
      fault    <= 1'b0;
      sweep_ok <= 1'b0;
      code_q   <= '0;
    end else if (!fault) begin
      if (cnt == LAST_CNT) begin
        cnt <= '0;
        if (rx != want) begin
          fault    <= 1'b1;
          sweep_ok <= 1'b0;
          code_q   <= step;
        end else if (step == LAST_STEP) begin
          step     <= '0;
          sweep_ok <= 1'b1;
        end else begin
          step <= step + 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pin_oe) == 1); // R2
  AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault && cnt != LAST_CNT) |=> $stable(pin_oe)); // R3
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault && cnt == LAST_CNT && step == LAST_STEP) |=> (pin_oe[0] || fault)); // R7
  AST_PASS_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sweep_ok) |-> pin_oe[0]); // R8
  AST_PASS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_ok |=> (sweep_ok || fault)); // R8
  AST_NO_PASS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(sweep_ok && fault)); // R9
  AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (fault && $stable(pin_oe) && $stable(fault_code))); // R9
  AST_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |-> fault_code == '0); // R10
endmodule

// File: tb/sim_loopback_walker.sv
module sim_loopback_walker;
  localparam int NP  = 120;
  localparam int TOT = 2 * NP;
  localparam int ST  = 16;
  localparam int ML  = 64;
  localparam int MN  = 22;
  localparam int SW  = $clog2(TOT);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TOT-1:0] pin_oe, pin_out, pin_in;
  logic sweep_ok, fault;
  logic [SW-1:0] fault_code;

  int brk = -1, shi = -1, slo = -1;
  int errs = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  loopback_walker #(.NPINS(NP), .SETTLE(ST), .MIR_LO(ML), .MIR_LEN(MN)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_oe(pin_oe), .pin_out(pin_out), .pin_in(pin_in),
    .sweep_ok(sweep_ok), .fault(fault), .fault_code(fault_code));

  function automatic int bpart(int i);
    if (i >= ML && i < ML + MN) return 2 * ML + MN - 1 - i;
    return i;
  endfunction

  // loopback fixture with fault injection
  logic [TOT-1:0] rxv;
  always_comb begin
    rxv = pin_oe & pin_out;
    for (int i = 0; i < NP; i++) begin
      if (i != brk) begin
        if (pin_oe[i] && pin_out[i]) rxv[NP + bpart(i)] = 1'b1;
        if (pin_oe[NP + bpart(i)] && pin_out[NP + bpart(i)]) rxv[i] = 1'b1;
      end
    end
    if (shi >= 0) rxv[shi] = 1'b1;
    if (slo >= 0) rxv[slo] = 1'b0;
  end
  assign pin_in = rxv;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, evaluated between edges
  int m_step = 0, m_cnt = 0, m_code = 0;
  bit m_pass = 0, m_fail = 0;

  function automatic int first_bit(logic [TOT-1:0] v);
    for (int i = 0; i < TOT; i++) if (v[i]) return i;
    return -1;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      m_step = 0; m_cnt = 0; m_code = 0; m_pass = 0; m_fail = 0;
    end else begin
      logic [TOT-1:0] e;
      bit good;
      e = '0;
      e[m_step] = 1'b1;
      chk(pin_oe == e && $countones(pin_oe) == 1, "R2 R4 driven pin", first_bit(pin_oe), m_step);
      chk(pin_out == e, "R2 driven value", first_bit(pin_out), m_step);
      chk(sweep_ok == m_pass, "R8 sweep_ok", sweep_ok, m_pass);
      chk(fault == m_fail, "R9 fault", fault, m_fail);
      chk(int'(fault_code) == m_code, "R9 R10 fault_code", fault_code, m_code);
      if (!m_fail) begin
        if (m_cnt == ST - 1) begin
          good = 1;
          for (int j = 0; j < NP; j++) begin
            if (m_step < NP) begin
              if (pin_in[NP + j] != (j == bpart(m_step))) good = 0;
            end else begin
              if (pin_in[j] != (j == bpart(m_step - NP))) good = 0;
            end
          end
          m_cnt = 0;
          if (!good) begin
            m_fail = 1; m_pass = 0; m_code = m_step;
          end else if (m_step == TOT - 1) begin
            m_step = 0; m_pass = 1;
          end else m_step++;
        end else m_cnt++;
      end
    end
  end

  task automatic go(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic look();
    @(negedge clk);
    #0.1;
  endtask

  task automatic do_reset();
    go(1);
    brk = -1; shi = -1; slo = -1;
    rst_n = 1'b0;
    go(3);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [TOT-1:0] held;
    go(3);
    rst_n = 1'b1;
    // reset state and settle window
    look();
    chk(pin_oe == TOT'(1), "R1 pin0 driven after reset", first_bit(pin_oe), 0);
    chk(!sweep_ok && !fault, "R1 flags clear", {sweep_ok, fault}, 0);
    chk(fault_code == 0, "R10 code idle", fault_code, 0);
    go(15);
    look();
    chk(pin_oe[0], "R3 hold through settle", first_bit(pin_oe), 0);
    go(1);
    look();
    chk(pin_oe[1], "R3 R4 advance after settle", first_bit(pin_oe), 1);
    go(1);
    shi = NP + 9;
    go(8);
    shi = -1;
    go(7);
    look();
    chk(!fault, "R3 early glitch ignored", fault, 0);
    go(3807);
    look();
    chk(pin_oe[TOT-1] && !sweep_ok, "R4 R8 last step before pass", first_bit(pin_oe), TOT - 1);
    go(1);
    look();
    chk(sweep_ok && pin_oe[0], "R7 R8 pass and wrap", {sweep_ok, pin_oe[0]}, 3);
    go(500);
    look();
    chk(sweep_ok && !fault, "R8 pass holds", sweep_ok, 1);

    // fault after pass, second sweep
    go(1);
    slo = 2;
    go(3840);
    look();
    chk(fault && fault_code == 8'(NP + 2), "R9 code after pass", fault_code, NP + 2);
    chk(!sweep_ok, "R9 pass cleared", sweep_ok, 0);
    held = pin_oe;
    go(50);
    look();
    chk(pin_oe == held && fault_code == 8'(NP + 2), "R9 frozen", first_bit(pin_oe), first_bit(held));

    do_reset();
    look();
    chk(!fault && fault_code == 0 && pin_oe[0], "R11 R10 reset from fault", fault_code, 0);

    // mirrored pairing: B pin 79 partners A pin 70
    go(1);
    slo = NP + 79;
    go(3840);
    look();
    chk(fault && fault_code == 8'd70, "R6 mirrored partner", fault_code, 70);

    do_reset();
    brk = 30;
    go(3840);
    look();
    chk(fault && fault_code == 8'd30, "R6 straight link open", fault_code, 30);

    // extra high in receiving bank
    do_reset();
    shi = NP + 3;
    go(20);
    look();
    chk(fault && fault_code == 8'd0, "R5 extra receiver high", fault_code, 0);

    // extra high in driving bank is ignored until it receives
    do_reset();
    shi = 7;
    go(NP * ST - 3);
    look();
    chk(!fault, "R5 driving bank not examined", fault, 0);
    go(40);
    look();
    chk(fault && fault_code == 8'(NP), "R5 fault on reverse step", fault_code, NP);

    // failure on the very last step
    do_reset();
    slo = 119;
    go(3840);
    look();
    chk(fault && fault_code == 8'hEF && !sweep_ok, "R9 last step code", fault_code, 239);

    do_reset();
    go(2);
    look();
    chk(!fault && !sweep_ok, "R11 clean restart", fault, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule